// File: doc/BRIEF.md
# Bidirectional Bit Scan Unit

This unit locates the first set bit of a source operand and writes its bit number into a destination value. The scan runs from either end of the operand. A forward scan starts at bit 0 and reports the lowest set bit. A reverse scan starts at the top bit of the selected size and reports the highest set bit. The operand is either 16 or 32 bits wide. In 16-bit mode only the low half of the source is examined, and only the low half of the destination is rewritten.

The caller presents the source, the size and direction selects, and the current destination contents, then pulses a valid strobe. One clock later the unit returns the new destination value, a zero flag and a one-cycle done strobe. When the examined source bits are all clear, the zero flag rises and the destination is passed back exactly as it came in.

Top module: `bsu_top`

## Requirements
- R1: A forward scan (`in_rev`=0) returns the bit number of the lowest set bit of the examined source bits. For example, 32'h01241240 gives 6.
- R2: A reverse scan (`in_rev`=1) returns the bit number of the highest set bit of the examined source bits. In 16-bit mode bit 15 is the top bit, and in 32-bit mode bit 31 is the top bit.
- R3: In 16-bit mode (`in_wide`=0) bits 31:16 of `in_src` have no effect on the index or on the zero flag.
- R4: `out_zero` is 1 exactly when every examined source bit is 0. Otherwise it is 0.
- R5: When the examined source is zero, `out_dst` equals the `in_dst` that was sampled with the strobe.
- R6: When a set bit is found in 32-bit mode, `out_dst` is the index zero-extended to 32 bits. In 16-bit mode, `out_dst[15:0]` is the index zero-extended to 16 bits, and `out_dst[31:16]` keeps `in_dst[31:16]`.
- R7: `out_done` is high for exactly one cycle: the cycle after `in_valid` is sampled high. It is low at every other time.
- R8: A synchronous active-high `rst` clears `out_done`, `out_zero` and `out_dst` to 0.
- R9: While `in_valid` is low, `out_dst` and `out_zero` hold their values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Starts a scan with the present inputs |
| in_src | input | 32 | Operand to scan |
| in_wide | input | 1 | 1 selects 32-bit mode, 0 selects 16-bit mode |
| in_rev | input | 1 | 1 selects a reverse scan, 0 selects a forward scan |
| in_dst | input | 32 | Current destination contents |
| out_dst | output | 32 | New destination value |
| out_zero | output | 1 | Examined source was all zero |
| out_done | output | 1 | Result valid, one-cycle pulse |

## Verification
The checker properties are evaluated on every clock. They cover the following:
- done is a single pulse that follows each strobe;
- the zero flag matches the sampled source;
- a zero source passes the destination through unchanged;
- the reported index always points at a bit that was set in the sampled source;
- the 16-bit result leaves the upper half alone;
- idle cycles keep the outputs steady.

The properties do not show that the chosen bit is the lowest or the highest set bit, or that the ignored upper source bits are really ignored. Reset clearing is not covered by them either. Those points come from the bench vectors, which use operands with several set bits and with junk in the upper half, and from the directed reset sequences.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
  // Scan direction as carried on in_rev
  typedef enum logic {
    SCAN_FWD = 1'b0,
    SCAN_REV = 1'b1
  } scan_dir_e;

  // Operand size as carried on in_wide
  typedef enum logic {
    SIZE_HALF = 1'b0,
    SIZE_FULL = 1'b1
  } scan_size_e;
endpackage

// File: rtl/bsu_condition.sv
// Masks the operand to the selected size and, for a reverse scan, mirrors it
// so that a single lowest-bit finder serves both directions.
module bsu_condition #(
  parameter int W  = 32,
  parameter int HW = 16
) (
  input  logic [W-1:0] src,
  input  logic         wide,
  input  logic         rev,
  output logic [W-1:0] cond
);
  import bsu_pkg::*;

  scan_dir_e  dir;
  scan_size_e size;
  assign dir  = scan_dir_e'(rev);
  assign size = scan_size_e'(wide);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic fwd_bit;
    logic rev_bit;
    if (i < HW) begin : g_low
      assign fwd_bit = src[i];
      assign rev_bit = (size == SIZE_FULL) ? src[W-1-i] : src[HW-1-i];
    end else begin : g_high
      assign fwd_bit = (size == SIZE_FULL) ? src[i] : 1'b0;
      assign rev_bit = (size == SIZE_FULL) ? src[W-1-i] : 1'b0;
    end
    assign cond[i] = (dir == SCAN_REV) ? rev_bit : fwd_bit;
  end
endmodule

// File: rtl/bsu_find_low.sv
// Reports the position of the lowest set bit and whether any bit is set.
module bsu_find_low #(
  parameter int W  = 32,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] pos,
  output logic          any
);
  always_comb begin
    pos = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) pos = IW'(i);
    end
  end

  assign any = |vec;
endmodule

// File: rtl/bsu_top.sv
module bsu_top #(
  parameter int W  = 32,
  parameter int HW = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_src,
  input  logic         in_wide,
  input  logic         in_rev,
  input  logic [W-1:0] in_dst,
  output logic [W-1:0] out_dst,
  output logic         out_zero,
  output logic         out_done
);
  import bsu_pkg::*;

  localparam int IW = $clog2(W);

  logic [W-1:0]  cond;
  logic [IW-1:0] low_pos;
  logic          found;
  logic [IW-1:0] index;
  logic [W-1:0]  next_dst;

  bsu_condition #(.W(W), .HW(HW)) u_cond (
    .src  (in_src),
    .wide (in_wide),
    .rev  (in_rev),
    .cond (cond)
  );

  bsu_find_low #(.W(W), .IW(IW)) u_find (
    .vec (cond),
    .pos (low_pos),
    .any (found)
  );

  // Map the mirrored position back to a bit number of the original operand
  always_comb begin
    if (scan_dir_e'(in_rev) == SCAN_FWD) begin
      index = low_pos;
    end else if (scan_size_e'(in_wide) == SIZE_FULL) begin
      index = IW'(W - 1) - low_pos;
    end else begin
      index = IW'(HW - 1) - low_pos;
    end
  end

  always_comb begin
    if (!found) begin
      next_dst = in_dst;
    end else if (scan_size_e'(in_wide) == SIZE_FULL) begin
      next_dst = {{(W-IW){1'b0}}, index};
    end else begin
      next_dst = {in_dst[W-1:HW], {(HW-IW){1'b0}}, index};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_dst  <= '0;
      out_zero <= 1'b0;
      out_done <= 1'b0;
    end else begin
      out_done <= in_valid;
      if (in_valid) begin
        out_dst  <= next_dst;
        out_zero <= ~found;
      end
    end
  end
endmodule

// File: rtl/bsu_checker.sv
module bsu_checker #(
  parameter int W  = 32,
  parameter int HW = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [W-1:0] in_src,
  input logic         in_wide,
  input logic         in_rev,
  input logic [W-1:0] in_dst,
  input logic [W-1:0] out_dst,
  input logic         out_zero,
  input logic         out_done
);
  localparam int IW = $clog2(W);

  logic unused_rev;
  assign unused_rev = in_rev;

  AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_done);  // R7
  AST_DONE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    out_done |-> $past(in_valid));  // R7
  AST_ZERO_MATCHES_SRC: assert property (@(posedge clk) disable iff (rst)
    out_done |-> (out_zero == ($past(in_wide) ? ($past(in_src) == '0)
                                              : ($past(in_src[HW-1:0]) == '0))));  // R4
  AST_ZERO_KEEPS_DST: assert property (@(posedge clk) disable iff (rst)
    (out_done && out_zero) |-> (out_dst == $past(in_dst)));  // R5
  AST_INDEX_HITS_SET_BIT: assert property (@(posedge clk) disable iff (rst)
    (out_done && !out_zero) |-> ((($past(in_src) >> out_dst[IW-1:0]) & W'(1)) != '0));  // R1
  AST_HALF_KEEPS_UPPER: assert property (@(posedge clk) disable iff (rst)
    (out_done && !out_zero && !$past(in_wide)) |->
      ((out_dst[W-1:HW] == $past(in_dst[W-1:HW])) && (out_dst[HW-1:IW-1] == '0)));  // R6
  AST_FULL_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
    (out_done && !out_zero && $past(in_wide)) |-> (out_dst[W-1:IW] == '0));  // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_dst) && $stable(out_zero)));  // R9
endmodule

bind bsu_top bsu_checker #(.W(W), .HW(HW)) u_bsu_checker (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_src   (in_src),
  .in_wide  (in_wide),
  .in_rev   (in_rev),
  .in_dst   (in_dst),
  .out_dst  (out_dst),
  .out_zero (out_zero),
  .out_done (out_done)
);

// File: tb/bsu_top_bench.sv
module bsu_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_src = '0;
  logic        in_wide = 1'b0;
  logic        in_rev = 1'b0;
  logic [31:0] in_dst = '0;
  logic [31:0] out_dst;
  logic        out_zero;
  logic        out_done;

  int checks = 0;
  int errors = 0;
  bit ended = 1'b0;

  always #4 clk = ~clk;

  bsu_top u_bsu_top (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_src(in_src),
    .in_wide(in_wide), .in_rev(in_rev), .in_dst(in_dst),
    .out_dst(out_dst), .out_zero(out_zero), .out_done(out_done)
  );

  typedef struct packed {
    logic [31:0] src;
    logic        wide;
    logic        rev;
    logic [31:0] dst;
    logic [31:0] exp_dst;
    logic        exp_zero;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'h01241240, 1'b1, 1'b0, 32'hAAAA5555, 32'h00000006, 1'b0}, // R1
    '{32'h01241240, 1'b1, 1'b1, 32'hAAAA5555, 32'h00000018, 1'b0}, // R2
    '{32'h80000000, 1'b1, 1'b0, 32'h00000000, 32'h0000001F, 1'b0}, // R1
    '{32'h00000001, 1'b1, 1'b1, 32'h12121212, 32'h00000000, 1'b0}, // R2
    '{32'hFFFF0000, 1'b0, 1'b0, 32'h12345678, 32'h12345678, 1'b1}, // R3 R5
    '{32'hFFFF0100, 1'b0, 1'b1, 32'h12345678, 32'h12340008, 1'b0}, // R3 R6
    '{32'h00018000, 1'b0, 1'b0, 32'hCAFEBEEF, 32'hCAFE000F, 1'b0}, // R6
    '{32'h00000000, 1'b1, 1'b1, 32'hDEADBEEF, 32'hDEADBEEF, 1'b1}, // R4 R5
    '{32'hFFFFFFFF, 1'b1, 1'b0, 32'h77777777, 32'h00000000, 1'b0}, // R1
    '{32'h0000FFFF, 1'b0, 1'b1, 32'h5A5A0000, 32'h5A5A000F, 1'b0}, // R2 R6
    '{32'h00010000, 1'b1, 1'b0, 32'hFFFFFFFF, 32'h00000010, 1'b0}, // R6
    '{32'h80000000, 1'b0, 1'b1, 32'h0F0F0F0F, 32'h0F0F0F0F, 1'b1}  // R3 R4
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drives one scan at a falling edge; returns after the result edge, at the next falling edge
  task automatic scan(input logic [31:0] s, input logic w, input logic r, input logic [31:0] d);
    @(negedge clk);
    in_src = s; in_wide = w; in_rev = r; in_dst = d; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!ended) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset done", {31'd0, out_done}, 32'd0);
    chk("R8 reset zero", {31'd0, out_zero}, 32'd0);
    chk("R8 reset dst", out_dst, 32'd0);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      scan(VECS[k].src, VECS[k].wide, VECS[k].rev, VECS[k].dst);
      chk($sformatf("R7 done vec %0d", k), {31'd0, out_done}, 32'd1);
      chk($sformatf("R1/R2/R6 dst vec %0d", k), out_dst, VECS[k].exp_dst);
      chk($sformatf("R4 zero vec %0d", k), {31'd0, out_zero}, {31'd0, VECS[k].exp_zero});
    end

    // R7: single pulse
    @(negedge clk);
    chk("R7 done drops", {31'd0, out_done}, 32'd0);

    // R9: idle inputs change, outputs hold
    scan(32'h00000100, 1'b1, 1'b0, 32'h0);
    in_src = 32'h00000000; in_dst = 32'hFFFFFFFF; in_rev = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 hold dst", out_dst, 32'h00000008);
    chk("R9 hold zero", {31'd0, out_zero}, 32'd0);
    chk("R7 no done idle", {31'd0, out_done}, 32'd0);

    // R7: back-to-back strobes, done stays high and each result lands
    @(negedge clk);
    in_src = 32'h00000010; in_wide = 1'b1; in_rev = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    chk("R7 b2b first", out_dst, 32'h00000004);
    in_src = 32'h40000000; in_rev = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7 b2b done", {31'd0, out_done}, 32'd1);
    chk("R2 b2b second", out_dst, 32'h0000001E);

    // R8: reset mid-operation clears zero flag and dst
    scan(32'h00000000, 1'b1, 1'b0, 32'h13572468);
    chk("R5 pre-reset dst", out_dst, 32'h13572468);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R8 zero cleared", {31'd0, out_zero}, 32'd0);
    chk("R8 dst cleared", out_dst, 32'd0);
    chk("R8 done cleared", {31'd0, out_done}, 32'd0);

    ended = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule